// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Cascade Outputs

This block is a reversible binary counter that runs on one system clock. It has two separate count strobes. A rising edge on the up strobe adds one to the count, and a rising edge on the down strobe subtracts one. Whichever strobe is idle is held high. Both strobes pass through a synchroniser and an edge detector before they reach the count register, so they may come from any clock domain or from another counter.

Two level-sensitive overrides sit above counting, and each is sampled on every clock. An active-high clear forces the count to zero, and it wins over everything else. An active-low preset copies the data inputs into the count. Presetting a start value lets the counter divide by any modulus N.

Two active-low cascade flags are derived from the count and the synchronised strobe levels:
- Carry goes low while the count is at its maximum and the up strobe is low.
- Borrow goes low while the count is zero and the down strobe is low.

Each flag rises as the count wraps. Carry can therefore drive the up strobe of the next stage, and borrow its down strobe, with no glue logic between them.

Top module: `updn_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and both carry_no and borrow_no are 1.
- R2: A rising edge on up_i, with down_i held high, increments count_o by one. The new value appears at the third rising clk_i edge after up_i goes high and not before.
- R3: A rising edge on down_i, with up_i held high, decrements count_o by one, with the same three-edge latency.
- R4: Counting wraps modulo 2^WIDTH. Counting up from 15 gives 0, and counting down from 0 gives 15 (WIDTH=4).
- R5: While clr_i is 1, count_o becomes 0 at the next clk_i edge, whatever load_ni, data_i and the strobes are doing.
- R6: While load_ni is 0 and clr_i is 0, count_o takes data_i at the next clk_i edge. Strobe edges that arrive during that time are discarded and have no later effect.
- R7: carry_no is 0 exactly when count_o is 15 and up_i has been low for at least two clk_i edges. Otherwise it is 1.
- R8: borrow_no is 0 exactly when count_o is 0 and down_i has been low for at least two clk_i edges. Otherwise it is 1.
- R9: If up_i and down_i produce rising edges that are detected in the same clk_i cycle, count_o does not change.
- R10: Two instances chained (carry_no to up_i and borrow_no to down_i of the upper stage) behave as one 8-bit up/down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear to zero, active high, highest priority |
| load_ni | input | 1 | Parallel preset, active low |
| data_i | input | WIDTH | Preset value |
| up_i | input | 1 | Count-up strobe, counts on rising edge |
| down_i | input | 1 | Count-down strobe, counts on rising edge |
| count_o | output | WIDTH | Current count |
| carry_no | output | 1 | Low while count is maximum and up strobe is low |
| borrow_no | output | 1 | Low while count is zero and down strobe is low |

## Verification
The assertions assume that a strobe stays at each level for at least two clock cycles, so no pulse is shorter than the synchroniser can see. They also assume that a strobe edge in flight is not expected to survive a preset or clear. The bench holds every strobe phase for four or more cycles and keeps the idle strobe high. The only exception is the deliberate same-cycle edge test (R9), in which both strobes rise at the same clock edge. Presets and clears are applied only while both strobes are idle high, except in the override tests (R5, R6), which pulse a strobe on purpose and then check that it was discarded.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  function automatic step_e decode_step(input logic inc, input logic dec);
    if (inc && !dec) return STEP_INC;
    if (dec && !inc) return STEP_DEC;
    return STEP_HOLD;
  endfunction
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= RST_VAL;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/updn_rise.sv
module updn_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  // starts high so an idle-high strobe is not seen as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (clr_i)         count_d = '0;
    else if (!load_ni) count_d = data_i;
    else begin
      unique case (step_i)
        STEP_INC: count_d = count_q + ONE;
        STEP_DEC: count_d = count_q - ONE;
        default:  count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/updn_flags.sv
module updn_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_lvl_i,
  input  logic             down_lvl_i,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  assign carry_no  = ~((count_i == MAX_VAL) & ~up_lvl_i);
  assign borrow_no = ~((count_i == '0) & ~down_lvl_i);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_no,
  output logic             borrow_no
);
  logic  up_lvl, down_lvl, up_rise, down_rise;
  step_e step;

  updn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(up_i), .q_o(up_lvl)
  );
  updn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_down (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(down_i), .q_o(down_lvl)
  );

  updn_rise u_rise_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(up_lvl), .rise_o(up_rise)
  );
  updn_rise u_rise_down (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(down_lvl), .rise_o(down_rise)
  );

  assign step = decode_step(up_rise, down_rise);

  updn_core #(.WIDTH(WIDTH)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .load_ni (load_ni),
    .data_i  (data_i),
    .step_i  (step),
    .count_o (count_o)
  );

  updn_flags #(.WIDTH(WIDTH)) u_flags (
    .count_i    (count_o),
    .up_lvl_i   (up_lvl),
    .down_lvl_i (down_lvl),
    .carry_no   (carry_no),
    .borrow_no  (borrow_no)
  );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             up_i,
  input logic             down_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_no,
  input logic             borrow_no
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0); // R5

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_ni) |=> count_o == $past(data_i)); // R6

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_ni) |=> ((count_o == $past(count_o)) ||
                             (count_o == $past(count_o) + ONE) ||
                             (count_o == $past(count_o) - ONE))); // R4

  AST_CARRY_ONLY_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != MAX_VAL) |-> carry_no); // R7

  AST_CARRY_NEEDS_UP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> ($past(up_i, 2) == 1'b0)); // R7

  AST_BORROW_ONLY_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> borrow_no); // R8

  AST_BORROW_NEEDS_DOWN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> ($past(down_i, 2) == 1'b0)); // R8
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_ni(load_ni),
  .data_i(data_i), .up_i(up_i), .down_i(down_i), .count_o(count_o),
  .carry_no(carry_no), .borrow_no(borrow_no)
);

// File: tb/updn_counter_test.sv
module updn_counter_test;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0;
  logic         load_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         up_i = 1'b1;
  logic         down_i = 1'b1;
  logic [W-1:0] count_o, hi_count;
  logic         carry_no, borrow_no, hi_carry_n, hi_borrow_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic carry_seen, borrow_seen;

  always #2.5 clk_i = ~clk_i;

  updn_counter #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_ni(load_ni),
    .data_i(data_i), .up_i(up_i), .down_i(down_i), .count_o(count_o),
    .carry_no(carry_no), .borrow_no(borrow_no)
  );

  // upper stage of the cascade (R10)
  updn_counter #(.WIDTH(W)) uut_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_ni(1'b1),
    .data_i('0), .up_i(carry_no), .down_i(borrow_no), .count_o(hi_count),
    .carry_no(hi_carry_n), .borrow_no(hi_borrow_n)
  );

  // {op, data, expected}: op 0 clear, 1 preset, 2 up, 3 down
  localparam logic [9:0] SEQ [13] = '{
    {2'd0, 4'd0,  4'd0},  {2'd1, 4'd13, 4'd13},
    {2'd2, 4'd0,  4'd14}, {2'd2, 4'd0,  4'd15}, {2'd2, 4'd0, 4'd0},
    {2'd2, 4'd0,  4'd1},  {2'd2, 4'd0,  4'd2},
    {2'd3, 4'd0,  4'd1},  {2'd3, 4'd0,  4'd0},  {2'd3, 4'd0, 4'd15},
    {2'd3, 4'd0,  4'd14}, {2'd3, 4'd0,  4'd13}, {2'd1, 4'd7, 4'd7}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_up();
    up_i = 1'b0; cyc(4); carry_seen = carry_no;
    up_i = 1'b1; cyc(6);
  endtask

  task automatic pulse_down();
    down_i = 1'b0; cyc(4); borrow_seen = borrow_no;
    down_i = 1'b1; cyc(6);
  endtask

  task automatic do_clear();
    clr_i = 1'b1; cyc(2); clr_i = 1'b0; cyc(2);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    data_i = v; load_ni = 1'b0; cyc(2); load_ni = 1'b1; cyc(2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    cyc(3);
    check("R1 count in reset", count_o, 0);
    check("R1 carry in reset", carry_no, 1);
    check("R1 borrow in reset", borrow_no, 1);
    rst_ni = 1'b1;
    cyc(2);

    // reference clear / preset / up / down walk
    for (int i = 0; i < 13; i++) begin
      logic [1:0] op;
      logic [3:0] dv, ev;
      {op, dv, ev} = SEQ[i];
      case (op)
        2'd0: do_clear();
        2'd1: do_load(dv);
        2'd2: begin
          pulse_up();
          check("R7 carry during up low", carry_seen, (ev == 4'd0) ? 0 : 1);
        end
        default: begin
          pulse_down();
          check("R8 borrow during down low", borrow_seen, (ev == 4'd15) ? 0 : 1);
        end
      endcase
      check((op == 2'd2) ? "R2 R4 up step" : (op == 2'd3) ? "R3 R4 down step" :
            (op == 2'd0) ? "R5 clear" : "R6 preset", count_o, ev);
    end
    check("R10 upper stage net zero", hi_count, 0);

    // R2 latency: unchanged after two edges, new value at the third
    up_i = 1'b0; cyc(4);
    up_i = 1'b1; cyc(2);
    check("R2 no change before third edge", count_o, 7);
    cyc(1);
    check("R2 change at third edge", count_o, 8);
    cyc(4);

    // R3 latency
    down_i = 1'b0; cyc(4);
    down_i = 1'b1; cyc(2);
    check("R3 no change before third edge", count_o, 8);
    cyc(1);
    check("R3 change at third edge", count_o, 7);
    cyc(4);

    // R9 both strobes rise together
    up_i = 1'b0; down_i = 1'b0; cyc(4);
    up_i = 1'b1; down_i = 1'b1; cyc(6);
    check("R9 simultaneous edges hold", count_o, 7);

    // R5 clear overrides preset and counting
    data_i = 4'd9; load_ni = 1'b0; clr_i = 1'b1;
    up_i = 1'b0; cyc(4); up_i = 1'b1; cyc(6);
    check("R5 clear wins", count_o, 0);
    load_ni = 1'b1; clr_i = 1'b0; cyc(4);
    check("R5 no late count after clear", count_o, 0);

    // R6 strobe during preset is discarded
    data_i = 4'd5; load_ni = 1'b0;
    up_i = 1'b0; cyc(4); up_i = 1'b1; cyc(6);
    check("R6 preset holds data", count_o, 5);
    load_ni = 1'b1; cyc(6);
    check("R6 discarded edge stays discarded", count_o, 5);

    // R7/R8 flags stay high while strobes idle at the extremes
    do_load(4'd15);
    check("R7 carry high when up idle", carry_no, 1);
    do_load(4'd0);
    check("R8 borrow high when down idle", borrow_no, 1);

    // R10 cascade through an up and a down wrap
    do_clear();
    do_load(4'd14);
    pulse_up(); pulse_up(); pulse_up();
    check("R10 low stage after up wrap", count_o, 1);
    check("R10 upper stage after up wrap", hi_count, 1);
    pulse_down(); pulse_down();
    check("R10 low stage after down wrap", count_o, 15);
    check("R10 upper stage after down wrap", hi_count, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule